// File: doc/BRIEF.md
# Byte-Stepped I2C Master

This block is an I2C bus master that moves one byte at a time under software control. Software programs a clock setting, loads a byte, and writes a command word that selects transmit or receive mode and asks for a START. The controller then shifts the byte out or in, handles the acknowledge bit, and stops with SCL held low. At that point it raises a pending flag and, if enabled, an interrupt. Nothing further happens on the bus until software clears the flag.

Once the flag is cleared, the controller does one of three things. It runs the next byte. It forms a repeated START followed by a new address byte, if that command was written while the bus was held. It forms a STOP, if that command was written while the bus was held. The bit rate is the system clock divided by a selectable prescaler (16 or 512) and then by the 4-bit divisor plus one. Both bus lines are open-drain: the block only pulls them low or lets them go, and it reads the real line levels back through two-flop synchronizers.

The register port is a plain write strobe with a select code, and every register can be read at any time on its own output. There is no back-pressure: software must not issue a new command while a byte is in flight. Slave operation and arbitration are not part of the block.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the control and status reads are 0x00, the interrupt output is low, and both lines are released.
- R2: Each clock phase lasts H = (P/2)·(div+1) system clocks, where P is 16 when control bit 6 is 0 and 512 when it is 1, and div is control bits 3:0. A high phase starts counting only once the synchronized SCL reads high, so SCL stays high for H+2 clocks.
- R3: Writing the status register with bit 5 = 1 and bit 4 = 1 while the bus is idle produces a START. SDA falls while SCL is high, and the data register byte is then sent MSB first. Status bit 5 reads 1 while the bus is held.
- R4: While SCL is high, SDA changes only to form a START or a STOP. Each transfer therefore shows exactly the START and STOP conditions that were commanded.
- R5: The pending flag (control bit 4) sets when a byte's ACK slot ends, and SCL stays low while the flag is set. Only a control write with bit 4 = 0 clears the flag; writing bit 4 = 1 has no effect.
- R6: Status bit 0 holds the SDA level sampled in the last ACK slot, where 1 means not acknowledged.
- R7: With status bits 7:6 = 11 (transmit mode), each resumed byte sends the data register.
- R8: With status bits 7:6 = 10 (receive mode), each resumed byte after the address is read MSB first into the data register. In its ACK slot the master pulls SDA low if control bit 7 is 1 and leaves SDA released if it is 0.
- R9: A status write with bit 5 = 1 while the bus is held, followed by clearing the pending flag, produces a repeated START and then sends the data register as an address.
- R10: A status write with bit 5 = 0 while the bus is held, followed by clearing the pending flag, produces a STOP. SDA rises while SCL is high, then both lines are released and status bit 5 reads 0.
- R11: The interrupt output is high exactly when the pending flag and control bit 5 are both 1.
- R12: A START request written with status bit 4 = 0 is ignored, and the bus stays idle.
- R13: Select codes are 0 = control, 1 = status, 2 = data, 3 = own address. The own-address register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select code |
| reg_wdata | input | 8 | Register write value |
| ctrl_rd | output | 8 | Control register read value |
| stat_rd | output | 8 | Status register read value |
| data_rd | output | 8 | Data shift register read value |
| own_addr_rd | output | 8 | Own-address register read value |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The assertions check four things on every cycle: SCL is held low whenever the flag is pending; the flag is never pending on an idle bus; both lines are free while the bus is idle; and the flag falls only after a clearing control write. They also check that a START without the enable bit leaves the bus idle. Only the bench scenarios can show the byte values seen by a modelled slave, the start and stop counts, the measured SCL high times under three clock settings, the acknowledge levels chosen by the master on read bytes, and the not-acknowledged case.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int DIV_W = 4;
  localparam int SYNC_STAGES = 2;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_OWN  = 2'd3;

  localparam logic [1:0] MODE_MRX = 2'b10;

  typedef enum logic [3:0] {
    PH_IDLE, PH_STA1, PH_STA2, PH_LO, PH_HI, PH_HOLD,
    PH_RS1, PH_RS2, PH_SP1, PH_SP2, PH_SP3
  } phase_e;

  typedef enum logic [1:0] {CMD_NONE, CMD_RESTART, CMD_STOP} cmd_e;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  // Idle bus level is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int MAX_HALF = (PRE_HI / 2) * (1 << DIV_W);
  localparam int CW = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;

  // One bus phase is half an SCL period.
  assign half = (pre_sel ? CW'(PRE_HI / 2) : CW'(PRE_LO / 2)) * (CW'(div) + CW'(1));
  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_go,
  input  logic       req_restart,
  input  logic       req_stop,
  input  logic       clr_pend,
  input  logic       data_wr,
  input  logic [7:0] data_in,
  input  logic       mode_rx,
  input  logic       ack_en,
  input  logic       scl_s,
  input  logic       sda_s,
  output logic       run,
  output logic       busy,
  output logic       pending,
  output logic       nack,
  output logic [7:0] shreg,
  output logic       scl_oe,
  output logic       sda_oe
);
  phase_e     ph;
  cmd_e       cmd;
  logic [3:0] bidx;
  logic       addr_byte;
  logic       is_tx;

  // The byte after a START is always the address and is always sent.
  assign is_tx = addr_byte || !mode_rx;
  assign busy  = (ph != PH_IDLE);
  // A high phase waits until the line is really seen high.
  assign run   = busy && (ph != PH_HOLD) && !((ph == PH_HI) && !scl_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cmd       <= CMD_NONE;
      bidx      <= '0;
      addr_byte <= 1'b0;
      pending   <= 1'b0;
      nack      <= 1'b0;
      shreg     <= '0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      if (data_wr)          shreg <= data_in;
      if (clr_pend)         pending <= 1'b0;
      if (req_restart)      cmd <= CMD_RESTART;
      else if (req_stop)    cmd <= CMD_STOP;

      case (ph)
        PH_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (start_go) begin
            ph        <= PH_STA1;
            sda_oe    <= 1'b1;
            addr_byte <= 1'b1;
            cmd       <= CMD_NONE;
          end
        end
        PH_STA1: if (tick) begin
          ph     <= PH_STA2;
          scl_oe <= 1'b1;
        end
        PH_STA2: if (tick) begin
          ph     <= PH_LO;
          bidx   <= '0;
          sda_oe <= is_tx ? ~shreg[7] : 1'b0;
        end
        PH_LO: if (tick) begin
          ph     <= PH_HI;
          scl_oe <= 1'b0;
        end
        PH_HI: if (tick) begin
          scl_oe <= 1'b1;
          if (bidx == 4'd8) begin
            nack      <= sda_s;
            pending   <= 1'b1;
            addr_byte <= 1'b0;
            ph        <= PH_HOLD;
          end else begin
            shreg <= {shreg[6:0], sda_s};
            bidx  <= bidx + 4'd1;
            ph    <= PH_LO;
            if (bidx == 4'd7) sda_oe <= is_tx ? 1'b0 : ack_en;
            else              sda_oe <= is_tx ? ~shreg[6] : 1'b0;
          end
        end
        PH_HOLD: begin
          scl_oe <= 1'b1;
          if (!pending) begin
            cmd <= CMD_NONE;
            case (cmd)
              CMD_RESTART: begin
                ph     <= PH_RS1;
                sda_oe <= 1'b0;
              end
              CMD_STOP: begin
                ph     <= PH_SP1;
                sda_oe <= 1'b1;
              end
              default: begin
                ph     <= PH_LO;
                bidx   <= '0;
                sda_oe <= is_tx ? ~shreg[7] : 1'b0;
              end
            endcase
          end
        end
        PH_RS1: if (tick) begin
          ph     <= PH_RS2;
          scl_oe <= 1'b0;
        end
        PH_RS2: if (tick) begin
          ph        <= PH_STA1;
          sda_oe    <= 1'b1;
          addr_byte <= 1'b1;
        end
        PH_SP1: if (tick) begin
          ph     <= PH_SP2;
          scl_oe <= 1'b0;
        end
        PH_SP2: if (tick) begin
          ph     <= PH_SP3;
          sda_oe <= 1'b0;
        end
        PH_SP3: if (tick) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctrl_rd,
  output logic [7:0] stat_rd,
  output logic [7:0] data_rd,
  output logic [7:0] own_addr_rd,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       scl_i,
  input  logic       sda_i
);
  logic             ack_en, pre_sel, irq_en, txrx_en;
  logic [DIV_W-1:0] div;
  logic [1:0]       mode;
  logic [7:0]       own_addr;
  logic             busy, pending, nack, run, tick;
  logic             wr_ctrl, wr_stat, wr_data, wr_own;
  logic             start_go, req_restart, req_stop, clr_pend;
  logic [1:0]       line_raw, line_s;
  logic [7:0]       shreg;

  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
  assign wr_data = reg_wr && (reg_sel == SEL_DATA);
  assign wr_own  = reg_wr && (reg_sel == SEL_OWN);

  assign clr_pend    = wr_ctrl && !reg_wdata[4];
  assign start_go    = wr_stat && reg_wdata[5] && reg_wdata[4] && !busy;
  assign req_restart = wr_stat && reg_wdata[5] && reg_wdata[4] && busy;
  assign req_stop    = wr_stat && !reg_wdata[5] && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en   <= 1'b0;
      pre_sel  <= 1'b0;
      irq_en   <= 1'b0;
      div      <= '0;
      mode     <= '0;
      txrx_en  <= 1'b0;
      own_addr <= '0;
    end else begin
      if (wr_ctrl) begin
        ack_en  <= reg_wdata[7];
        pre_sel <= reg_wdata[6];
        irq_en  <= reg_wdata[5];
        div     <= reg_wdata[DIV_W-1:0];
      end
      if (wr_stat) begin
        mode    <= reg_wdata[7:6];
        txrx_en <= reg_wdata[4];
      end
      if (wr_own) own_addr <= reg_wdata;
    end
  end

  // Index 1 carries SCL, index 0 carries SDA.
  assign line_raw = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g])
    );
  end

  i2cm_phase_timer #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .div(div), .tick(tick)
  );

  i2cm_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_go(start_go),
    .req_restart(req_restart), .req_stop(req_stop), .clr_pend(clr_pend),
    .data_wr(wr_data), .data_in(reg_wdata), .mode_rx(mode == MODE_MRX),
    .ack_en(ack_en), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .run(run), .busy(busy), .pending(pending), .nack(nack), .shreg(shreg),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign ctrl_rd     = {ack_en, pre_sel, irq_en, pending, div};
  assign stat_rd     = {mode, busy, txrx_en, 3'b000, nack};
  assign data_rd     = shreg;
  assign own_addr_rd = own_addr;
  assign irq         = pending && irq_en;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_sel,
  input logic [7:0] reg_wdata,
  input logic [7:0] ctrl_rd,
  input logic [7:0] stat_rd,
  input logic       scl_oe,
  input logic       sda_oe
);
  a_r5_pending_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[4] |-> scl_oe);

  a_r5_pending_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[4] |-> stat_rd[5]);

  a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rd[4]) |-> $past(reg_wr && (reg_sel == 2'd0) && !reg_wdata[4]));

  a_r10_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd[5] |-> (!scl_oe && !sda_oe));

  a_r12_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == 2'd1) && !reg_wdata[4] && !stat_rd[5]) |=> !stat_rd[5]);
endmodule

bind i2c_byte_master i2cm_checker u_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] ctrl_rd, stat_rd, data_rd, own_addr_rd;
  logic       irq, scl_oe, sda_oe;
  logic       sl_drv = 1'b0;
  logic       scl_ln, sda_ln;

  assign scl_ln = ~scl_oe;
  assign sda_ln = ~(sda_oe | sl_drv);

  always #2 clk = ~clk;

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd),
    .data_rd(data_rd), .own_addr_rd(own_addr_rd), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_i(scl_ln), .sda_i(sda_ln)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural slave and bus monitor.
  int         n_start = 0, n_stop = 0, bitc = 0, hi_cnt = 0, hi_len = 0;
  bit         prv_scl = 1'b1, prv_sda = 1'b1, first = 1'b0, sl_tx = 1'b0;
  bit         sl_ack_en = 1'b1, last_ack = 1'b0;
  bit [7:0]   sh = 8'd0, txb = 8'd0;
  bit [7:0]   rxq[$];
  bit [7:0]   txq[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_ln && prv_scl && prv_sda && !sda_ln) begin
        n_start++; bitc = 0; first = 1'b1; sl_tx = 1'b0; sl_drv <= 1'b0;
      end else if (scl_ln && prv_scl && !prv_sda && sda_ln) begin
        n_stop++; sl_tx = 1'b0;
      end else if (scl_ln && !prv_scl) begin
        if (bitc < 8) begin
          sh = {sh[6:0], sda_ln}; bitc++;
        end else begin
          last_ack = sda_ln; bitc = 0;
          if (!sl_tx) begin
            rxq.push_back(sh);
            if (first) begin
              first = 1'b0;
              if (sh[0] && sl_ack_en) sl_tx = 1'b1;
            end
          end else if (sda_ln) sl_tx = 1'b0;
        end
      end else if (!scl_ln && prv_scl) begin
        if (bitc == 8 && !sl_tx) sl_drv <= sl_ack_en;
        else if (sl_tx && bitc == 0 && txq.size() > 0) begin
          txb = txq.pop_front(); sl_drv <= ~txb[7];
        end else if (sl_tx && bitc < 8) sl_drv <= ~txb[7-bitc];
        else sl_drv <= 1'b0;
      end
      if (scl_ln) hi_cnt++;
      else if (prv_scl) begin hi_len = hi_cnt; hi_cnt = 0; end
      prv_scl = scl_ln; prv_sda = sda_ln;
      // Every-clock reference comparison.
      chk("R11 irq", irq, ctrl_rd[4] & ctrl_rd[5]);
      if (!stat_rd[5]) chk("R10 idle lines", {scl_ln, sda_ln}, 2'b11);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_pend(input string tag);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (ctrl_rd[4]) return;
    end
    chk({tag, " pending timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!stat_rd[5]) return;
    end
    chk({tag, " idle timeout"}, 0, 1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=expired expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_rd, 8'h00);
    chk("R1 stat", stat_rd, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_ln, sda_ln}, 2'b11);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R13 own address
    wr(2'd3, 8'h5A);
    chk("R13 own addr", own_addr_rd, 8'h5A);

    // R12 start without enable
    wr(2'd1, 8'h20);
    repeat (40) @(negedge clk);
    chk("R12 stat", stat_rd, 8'h00);
    chk("R12 no start", n_start, 0);

    // R3 R7 write transfer
    wr(2'd0, 8'hA0);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R3");
    chk("R3 start count", n_start, 1);
    chk("R3 addr byte", rxq.size() > 0 ? rxq[0] : 9'h1FF, 8'hA0);
    chk("R3 busy", stat_rd[5], 1);
    chk("R6 ack seen", stat_rd[0], 0);
    chk("R11 irq on pending", irq, 1);
    chk("R2 high time div0", hi_len, 10);
    repeat (100) @(negedge clk);
    chk("R5 scl held", scl_ln, 0);
    wr(2'd0, 8'hB0);
    repeat (50) @(negedge clk);
    chk("R5 write one ignored", ctrl_rd[4], 1);
    chk("R5 scl still held", scl_ln, 0);
    wr(2'd2, 8'h3C);
    wr(2'd0, 8'hA0);
    wait_pend("R7");
    chk("R7 data byte", rxq.size() > 1 ? rxq[1] : 9'h1FF, 8'h3C);

    // R9 R8 repeated start and read
    txq.push_back(8'h96);
    txq.push_back(8'h5B);
    wr(2'd2, 8'hA1);
    wr(2'd1, 8'hB0);
    wr(2'd0, 8'hA0);
    wait_pend("R9");
    chk("R9 start count", n_start, 2);
    chk("R9 addr byte", rxq.size() > 2 ? rxq[2] : 9'h1FF, 8'hA1);
    wr(2'd0, 8'hA0);
    wait_pend("R8a");
    chk("R8 read byte 1", data_rd, 8'h96);
    chk("R8 master ack low", last_ack, 0);
    wr(2'd0, 8'h20);
    wait_pend("R8b");
    chk("R8 read byte 2", data_rd, 8'h5B);
    chk("R8 master nack", last_ack, 1);
    chk("R6 nack flag", stat_rd[0], 1);
    chk("R11 irq read", irq, 1);

    // R10 stop
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h00);
    wait_idle("R10");
    chk("R10 stop count", n_stop, 1);
    chk("R10 not busy", stat_rd[5], 0);
    chk("R10 irq low", irq, 0);

    // R6 nack by slave, R2 divisor 3
    sl_ack_en = 1'b0;
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h42);
    wr(2'd1, 8'hF0);
    wait_pend("R6");
    chk("R6 slave nack", stat_rd[0], 1);
    chk("R2 high time div3", hi_len, 34);
    chk("R11 irq masked", irq, 0);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h03);
    wait_idle("R6 stop");
    chk("R10 stop count 2", n_stop, 2);

    // R2 large prescaler
    sl_ack_en = 1'b1;
    wr(2'd0, 8'h40);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R2");
    chk("R2 high time pre512", hi_len, 258);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h40);
    wait_idle("R2 stop");

    // R4 only commanded conditions on the bus
    chk("R4 starts", n_start, 4);
    chk("R4 stops", n_stop, 3);
    finish_run();
  end
endmodule